// File: doc/BRIEF.md
# Pixel Clock Divider Search Engine

This block receives a requested pixel clock in kHz and finds the integer PLL multiplier `n`, the output divider `m` and a doubler choice whose generated clock equals the request. When no exact match exists, it picks the closest clock that lies below the request. The generated clock is `3000*n/m` kHz when the doubler is off and `6000*n/m` kHz when it is on. The PLL itself then runs at `n` times 3 MHz.

The engine tests one candidate at a time. It walks the divider from its largest value down to 1. At each divider it first tests the normal candidate, and then, for odd dividers only, the doubled candidate. Each candidate needs two integer divisions, which share one sequential restoring divider. The engine waits for each quotient before going on.

Software or a sequencer loads the request with a one-cycle `start` pulse. It then waits for the one-cycle `done` strobe and reads the chosen settings.

Top module: `pclk_div_search`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `best_n`, `best_m`, `best_double` and `pll_khz` are all 0.
- R2: A `start` pulse while idle latches `dot_khz`, raises `busy` in the next cycle and clears the stored best to n=0, m=0, double=0.
- R3: For each m from 15 down to 1, the normal candidate is n = floor(m*dot/3000), and its clock is floor(3000*n/m). Its undershoot is dot minus that clock. The final result is the candidate with the smallest undershoot.
- R4: The doubled candidate uses 6000 in place of 3000 and is tested only for odd m. When chosen, `best_double` is 1; otherwise it is 0.
- R5: A candidate counts only when 9 <= n <= 127. If no candidate counts, the result stays n=0, m=0, double=0.
- R6: A candidate replaces the stored best only when its undershoot is strictly smaller. An equal undershoot keeps the earlier candidate in scan order: larger m first, and normal before doubled at the same m. The starting undershoot is 0x0FFFFFFF.
- R7: `done` is high for exactly one cycle, in the cycle after the last candidate (m=1, doubled) has been tested. `busy` is 0 in that cycle.
- R8: A `start` while `busy` is 1 is ignored, and the running search returns the result for the first request. A `start` in the cycle where `done` is high is accepted as a new request.
- R9: `pll_khz` equals 3000 times `best_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request pulse |
| dot_khz | input | DOT_W (20) | Requested pixel clock in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search strobe |
| best_n | output | 7 | Chosen PLL multiplier |
| best_m | output | 4 | Chosen output divider |
| best_double | output | 1 | Doubled reference chosen |
| pll_khz | output | 19 | PLL frequency of the chosen multiplier, in kHz |

## Verification
Two functions can meet in one cycle: the end of one search, signalled by `done`, and the acceptance of the next `start`. This happens because the engine is already idle while `done` is high. The bench provokes the overlap by raising `start` with a new request in the very cycle where it sees `done`. It then judges the overlap in three ways: `busy` must rise in the next cycle, the old strobe must drop, and the second result must match the bench's own search for the new request. A related check pulses `start` in the middle of a search and expects the first request's result to survive unchanged.

// File: rtl/pclk_search_pkg.sv
package pclk_search_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LN, ST_WN, ST_LV, ST_WV, ST_ADV
  } srch_state_e;

  // multiplier usable when lo <= q <= hi
  function automatic logic n_in_range(input logic [31:0] q,
                                      input int unsigned lo,
                                      input int unsigned hi);
    return (q >= lo) && (q <= hi);
  endfunction

  // PLL output in kHz for a given multiplier
  function automatic logic [31:0] pll_of(input logic [31:0] n,
                                         input int unsigned ref_khz);
    return n * ref_khz;
  endfunction

endpackage

// File: rtl/pcs_rdiv.sv
module pcs_rdiv #(
  parameter int DVD_W = 24,
  parameter int DSR_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DSR_W-1:0] divisor,
  output logic             done,
  output logic [DVD_W-1:0] quotient,
  output logic [DSR_W-1:0] remainder
);
  localparam int CNT_W = $clog2(DVD_W + 1);
  localparam int PW    = DVD_W + DSR_W + 1;

  logic [DVD_W-1:0] q_r, dvd_l;
  logic [DSR_W-1:0] rem_r, dsr_l;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [DSR_W:0]   acc, acc_sub;
  logic             fits;
  logic [DSR_W-1:0] rem_nx;

  always_comb begin
    acc     = {rem_r, q_r[DVD_W-1]};
    acc_sub = acc - {1'b0, dsr_l};
    fits    = acc >= {1'b0, dsr_l};
    rem_nx  = fits ? acc_sub[DSR_W-1:0] : acc[DSR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_r <= '0; dvd_l <= '0; rem_r <= '0; dsr_l <= '0;
      cnt <= '0; run <= 1'b0; done <= 1'b0;
    end else if (start) begin
      q_r   <= dividend;
      dvd_l <= dividend;
      dsr_l <= divisor;
      rem_r <= '0;
      cnt   <= CNT_W'(DVD_W);
      run   <= 1'b1;
      done  <= 1'b0;
    end else if (run) begin
      q_r   <= {q_r[DVD_W-2:0], fits};
      rem_r <= rem_nx;
      cnt   <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) begin
        run  <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign quotient  = q_r;
  assign remainder = rem_r;

  // R3
  div_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((PW'(quotient) * PW'(dsr_l) + PW'(remainder) == PW'(dvd_l))
              && (remainder < dsr_l)));

endmodule

// File: rtl/pcs_best.sv
module pcs_best #(
  parameter int          N_W       = 7,
  parameter int          M_W       = 4,
  parameter int          DIFF_W    = 28,
  parameter logic [63:0] DIFF_INIT = 64'h0FFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              offer,
  input  logic [N_W-1:0]    c_n,
  input  logic [M_W-1:0]    c_m,
  input  logic              c_dbl,
  input  logic [DIFF_W-1:0] c_diff,
  output logic [N_W-1:0]    b_n,
  output logic [M_W-1:0]    b_m,
  output logic              b_dbl
);
  logic [DIFF_W-1:0] b_diff;
  logic              take;

  assign take = offer && (c_diff < b_diff);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      b_n <= '0; b_m <= '0; b_dbl <= 1'b0;
      b_diff <= DIFF_W'(DIFF_INIT);
    end else if (take) begin
      b_n <= c_n; b_m <= c_m; b_dbl <= c_dbl;
      b_diff <= c_diff;
    end
  end

  // R6
  best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> b_diff <= $past(b_diff));

  // R6
  tie_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (offer && !clear && c_diff == b_diff) |=> $stable({b_n, b_m, b_dbl}));

endmodule

// File: rtl/pclk_div_search.sv
module pclk_div_search
  import pclk_search_pkg::*;
#(
  parameter int DOT_W   = 20,
  parameter int M_MAX   = 15,
  parameter int N_MIN   = 9,
  parameter int N_MAX   = 127,
  parameter int REF_KHZ = 3000
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start,
  input  logic [DOT_W-1:0]                       dot_khz,
  output logic                                   busy,
  output logic                                   done,
  output logic [$clog2(N_MAX+1)-1:0]             best_n,
  output logic [$clog2(M_MAX+1)-1:0]             best_m,
  output logic                                   best_double,
  output logic [$clog2(N_MAX*REF_KHZ+1)-1:0]     pll_khz
);
  localparam int M_W    = $clog2(M_MAX + 1);
  localparam int N_W    = $clog2(N_MAX + 1);
  localparam int PLL_W  = $clog2(N_MAX * REF_KHZ + 1);
  localparam int PROD_W = DOT_W + M_W;
  localparam int REF2   = 2 * REF_KHZ;
  localparam int REF_W  = $clog2(REF2 + 1);
  localparam int DSR_W  = (REF_W > M_W) ? REF_W : M_W;
  localparam int DIFF_W = (DOT_W + 1 > 28) ? DOT_W + 1 : 28;

  srch_state_e       state;
  logic [DOT_W-1:0]  dot_l;
  logic [M_W-1:0]    m_r;
  logic              dbl_r;
  logic [N_W-1:0]    n_r;

  logic              div_start, div_done;
  logic [PROD_W-1:0] div_dvd, div_q;
  logic [DSR_W-1:0]  div_dsr, div_rem, ref_sel;
  logic              n_ok, clear, offer, last;
  logic [DIFF_W-1:0] diff;

  assign ref_sel   = dbl_r ? DSR_W'(REF2) : DSR_W'(REF_KHZ);
  assign div_start = (state == ST_LN) || (state == ST_LV);
  assign n_ok      = n_in_range(32'(div_q), N_MIN, N_MAX);
  assign diff      = DIFF_W'(dot_l) - DIFF_W'(div_q);
  assign clear     = (state == ST_IDLE) && start;
  assign offer     = (state == ST_WV) && div_done;
  assign last      = (m_r == M_W'(1)) && (dbl_r || !m_r[0]);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    if (state == ST_LV) begin
      div_dvd = PROD_W'(ref_sel) * PROD_W'(n_r);
      div_dsr = DSR_W'(m_r);
    end else begin
      div_dvd = PROD_W'(m_r) * PROD_W'(dot_l);
      div_dsr = ref_sel;
    end
  end

  pcs_rdiv #(.DVD_W(PROD_W), .DSR_W(DSR_W)) div_u (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .dividend(div_dvd), .divisor(div_dsr),
    .done(div_done), .quotient(div_q), .remainder(div_rem)
  );

  pcs_best #(.N_W(N_W), .M_W(M_W), .DIFF_W(DIFF_W)) best_u (
    .clk(clk), .rst_n(rst_n), .clear(clear), .offer(offer),
    .c_n(n_r), .c_m(m_r), .c_dbl(dbl_r), .c_diff(diff),
    .b_n(best_n), .b_m(best_m), .b_dbl(best_double)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; dot_l <= '0; m_r <= '0; dbl_r <= 1'b0;
      n_r <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          dot_l <= dot_khz;
          m_r   <= M_W'(M_MAX);
          dbl_r <= 1'b0;
          state <= ST_LN;
        end
        ST_LN: state <= ST_WN;
        ST_WN: if (div_done) begin
          if (n_ok) begin
            n_r   <= div_q[N_W-1:0];
            state <= ST_LV;
          end else begin
            state <= ST_ADV;
          end
        end
        ST_LV: state <= ST_WV;
        ST_WV: if (div_done) state <= ST_ADV;
        ST_ADV: begin
          if (last) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else if (!dbl_r && m_r[0]) begin
            dbl_r <= 1'b1;
            state <= ST_LN;
          end else begin
            m_r   <= m_r - 1'b1;
            dbl_r <= 1'b0;
            state <= ST_LN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign pll_khz = PLL_W'(pll_of(32'(best_n), REF_KHZ));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R4
  dbl_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (offer && dbl_r) |-> m_r[0]);

  // R5
  n_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (best_n == '0) || (best_n >= N_W'(N_MIN) && best_n <= N_W'(N_MAX)));

endmodule

// File: tb/pclk_div_search_tb_top.sv
module pclk_div_search_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] dot_khz = '0;
  logic        busy, done, best_double;
  logic [6:0]  best_n;
  logic [3:0]  best_m;
  logic [18:0] pll_khz;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pclk_div_search dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dot_khz(dot_khz),
    .busy(busy), .done(done), .best_n(best_n), .best_m(best_m),
    .best_double(best_double), .pll_khz(pll_khz)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // independent restatement of the search
  task automatic model(input int d, output int bn, output int bm, output int bd);
    longint bdiff = 64'h0FFF_FFFF;
    bn = 0; bm = 0; bd = 0;
    for (int m = 15; m >= 1; m--) begin
      for (int k = 0; k < 2; k++) begin
        int r, n, v;
        if (k == 1 && (m % 2) == 0) continue;
        r = (k == 1) ? 6000 : 3000;
        n = (m * d) / r;
        if (n >= 9 && n <= 127) begin
          v = (r * n) / m;
          if (longint'(d - v) < bdiff) begin
            bdiff = d - v; bn = n; bm = m; bd = k;
          end
        end
      end
    end
  endtask

  task automatic pulse_start(input int d);
    start = 1'b1; dot_khz = 20'(d);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    chk("R7", "done seen", int'(ok), 1);
  endtask

  task automatic judge(input string req, input int d);
    int en, em, ed;
    model(d, en, em, ed);
    chk(req, $sformatf("n for %0d", d), int'(best_n), en);
    chk(req, $sformatf("m for %0d", d), int'(best_m), em);
    chk(req, $sformatf("double for %0d", d), int'(best_double), ed);
    chk("R9", "pll_khz", int'(pll_khz), 3000 * en);
    chk("R7", "busy low at done", int'(busy), 0);
  endtask

  task automatic run_one(input string req, input int d);
    bit ok;
    pulse_start(d);
    chk("R2", "busy after start", int'(busy), 1);
    wait_done(ok);
    judge(req, d);
    @(negedge clk);
    chk("R7", "done one cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "best_n", int'(best_n), 0);
    chk("R1", "best_m", int'(best_m), 0);
    chk("R1", "best_double", int'(best_double), 0);
    chk("R1", "pll_khz", int'(pll_khz), 0);
  endtask

  task automatic t_tie();
    run_one("R6", 27000);
    chk("R6", "tie keeps m=14", int'(best_m), 14);
    chk("R6", "tie keeps n=126", int'(best_n), 126);
  endtask

  task automatic t_none();
    run_one("R5", 0);
    chk("R5", "zero n", int'(best_n), 0);
    run_one("R5", 1000);
    chk("R5", "small m", int'(best_m), 0);
  endtask

  task automatic t_dbl();
    run_one("R4", 760000);
    chk("R4", "double chosen", int'(best_double), 1);
    chk("R4", "n=126", int'(best_n), 126);
    chk("R4", "m=1", int'(best_m), 1);
  endtask

  task automatic t_main();
    run_one("R3", 148500);
    chk("R3", "148500 n=99", int'(best_n), 99);
    run_one("R3", 25175);
    run_one("R3", 65000);
    run_one("R3", 108000);
    run_one("R3", 40000);
    run_one("R3", 1000000);
  endtask

  task automatic t_clear();
    bit ok;
    run_one("R3", 65000);
    pulse_start(0);
    chk("R2", "best cleared n", int'(best_n), 0);
    chk("R2", "best cleared m", int'(best_m), 0);
    wait_done(ok);
    judge("R5", 0);
  endtask

  task automatic t_ignore();
    bit ok;
    pulse_start(148500);
    repeat (40) @(negedge clk);
    pulse_start(27000);
    chk("R8", "still busy", int'(busy), 1);
    wait_done(ok);
    judge("R8", 148500);
  endtask

  task automatic t_b2b();
    bit ok;
    pulse_start(65000);
    wait_done(ok);
    judge("R8", 65000);
    pulse_start(108000);
    chk("R8", "restart busy", int'(busy), 1);
    chk("R8", "old done dropped", int'(done), 0);
    wait_done(ok);
    judge("R8", 108000);
  endtask

  initial begin
    #1500000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tie();
    t_none();
    t_dbl();
    t_main();
    t_clear();
    t_ignore();
    t_b2b();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule